// File: doc/BRIEF.md
# Vertical Channel Mode Selector

This block decides which vertical input channel, or which pair of channels, is passed to the display path of a two-channel oscilloscope. It reads three controls. The first is a three-position channel switch: channel 1 only, both channels, or channel 2 only. The second is a three-position combine switch: summed, alternate or chopped. The third is a flag that is high while the instrument is in X-Y mode. From these controls it drives two registered channel-enable lines and a registered flag that marks summed operation.

Selection is held in a single flip-flop. The flip-flop has active-low set and clear inputs, and both are sampled on the system clock. The channel-1 enable is the true output and the channel-2 enable is the complementary output. When set and clear are both active, both outputs go high. A separate detector watches for both enables high and raises the sum flag. The flip-flop toggles in the two time-shared modes. In alternate mode an end-of-sweep pulse toggles it. In chopped mode a free-running chop clock toggles it. Both timing inputs arrive asynchronously and are synchronised before their rising edges are detected.

Top module: `vchan_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become `ch1_en`=1, `ch2_en`=0 and `add_en`=0.
- R2: With `xy_mode`=0 and `chan_sw`=2'b00 (channel 1), the next clock edge gives `ch1_en`=1 and `ch2_en`=0.
- R3: With `xy_mode`=0 and `chan_sw`=2'b10 (channel 2), the next clock edge gives `ch1_en`=0 and `ch2_en`=1.
- R4: With `xy_mode`=0, `chan_sw`=2'b01 (both) and `mode_sw`=2'b00 (sum), the next clock edge gives `ch1_en`=1 and `ch2_en`=1.
- R5: `add_en` is 1 exactly one clock after a cycle in which both enables are 1. It is 0 one clock after any other cycle.
- R6: With `chan_sw`=2'b01 and `mode_sw`=2'b01 (alternate), each rising edge of `sweep_end` swaps the enables. The swap appears at the third rising clock edge after the input rises. `chop_clk` has no effect in this mode.
- R7: With `chan_sw`=2'b01 and `mode_sw`=2'b10 (chopped), each rising edge of `chop_clk` swaps the enables, with the same latency as R6. `sweep_end` has no effect in this mode.
- R8: When the mode moves from sum to alternate or chopped, both enables stay high until the first toggle event. That event leaves only `ch1_en` high.
- R9: While `xy_mode`=1, the enables hold their values whatever the switches and the timing inputs do.
- R10: `mode_sw` and both timing inputs have no effect unless `chan_sw` is 2'b01.
- R11: The unused codes `chan_sw`=2'b11 and, when `chan_sw`=2'b01, `mode_sw`=2'b11 hold the enables unchanged.
- R12: Once reset has been applied, `ch1_en` and `ch2_en` are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xy_mode | input | 1 | High while the instrument is in X-Y mode |
| chan_sw | input | 2 | Channel switch: 00 ch1, 01 both, 10 ch2, 11 unused |
| mode_sw | input | 2 | Combine switch: 00 sum, 01 alternate, 10 chopped, 11 unused |
| sweep_end | input | 1 | Asynchronous end-of-sweep pulse |
| chop_clk | input | 1 | Asynchronous free-running chop clock |
| ch1_en | output | 1 | Channel 1 gate enable (registered) |
| ch2_en | output | 1 | Channel 2 gate enable (registered) |
| add_en | output | 1 | Sum-mode flag, high when both gates are on (registered) |

## Verification
The assertions check the following on every cycle:
- the forced selections for the channel-1, channel-2 and sum positions;
- the one-clock delay of the sum flag behind the two enables;
- the hold in X-Y mode;
- the single-cycle width of each synchronised event pulse;
- the rule that at least one channel is always enabled.

Some behaviours depend on a sequence of events, so only the bench scenarios can show them:
- the three-clock latency of a toggle;
- which timing input is ignored in each time-shared mode;
- the state left behind when sum mode gives way to alternate or chopped;
- the hold on the unused codes.

// File: rtl/vsel_pkg.sv
// Package: shared encodings for the vertical channel mode selector.
// Assumes the switch codes below are fixed by the front-panel wiring.
package vsel_pkg;

    typedef enum logic [1:0] {
        CHSW_CH1  = 2'b00,
        CHSW_BOTH = 2'b01,
        CHSW_CH2  = 2'b10,
        CHSW_RSVD = 2'b11
    } chsw_e;

    typedef enum logic [1:0] {
        MODE_ADD  = 2'b00,
        MODE_ALT  = 2'b01,
        MODE_CHOP = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        TOG_NONE  = 2'b00,
        TOG_SWEEP = 2'b01,
        TOG_CHOP  = 2'b10
    } togsrc_e;

    localparam int EVT_SWEEP = 0;
    localparam int EVT_CHOP  = 1;
    localparam int NUM_EVT   = 2;

endpackage

// File: rtl/vsel_decode.sv
// Module: vsel_decode
// Turns the switch positions into active-low set/clear requests for the
// select flip-flop and picks which timing event, if any, may toggle it.
// Assumes: purely combinational; the caller registers the result.
module vsel_decode
    import vsel_pkg::*;
(
    input  logic    xy_mode,
    input  chsw_e   chan,
    input  mode_e   mode,
    output logic    set_n,
    output logic    clr_n,
    output togsrc_e tog_src
);

    // Decode switch positions; X-Y mode and unused codes request nothing.
    always_comb begin
        set_n   = 1'b1;
        clr_n   = 1'b1;
        tog_src = TOG_NONE;
        if (!xy_mode) begin
            unique case (chan)
                CHSW_CH1: set_n = 1'b0;
                CHSW_CH2: clr_n = 1'b0;
                CHSW_BOTH: begin
                    unique case (mode)
                        MODE_ADD: begin
                            set_n = 1'b0;
                            clr_n = 1'b0;
                        end
                        MODE_ALT:  tog_src = TOG_SWEEP;
                        MODE_CHOP: tog_src = TOG_CHOP;
                        default:   tog_src = TOG_NONE;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vsel_evt.sv
// Module: vsel_evt
// Synchronises one asynchronous timing input through STAGES flops and
// emits a single-cycle pulse on each rising edge of the synchronised level.
// Assumes: STAGES >= 2; the input stays high and low for longer than one
// clock, so that no edge is lost.
module vsel_evt #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_pulse
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    // Shift the raw input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], evt_in};
    end

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Rising edge of the synchronised level.
    assign evt_pulse = sync_q[LAST] & ~prev_q;

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse)
        else $error("event pulse wider than one cycle");

endmodule

// File: rtl/vsel_selff.sv
// Module: vsel_selff
// The channel select flip-flop. q is the channel-1 enable and qn the
// channel-2 enable. Set and clear are active low and are sampled on the
// clock. When both are active they override the data path and both outputs
// read high. Otherwise a toggle enable loads d = qn.
// Assumes: reset leaves channel 1 selected.
module vsel_selff (
    input  logic clk,
    input  logic rst_n,
    input  logic set_n,
    input  logic clr_n,
    input  logic tog_en,
    output logic q,
    output logic qn
);

    logic d;

    // The toggle data comes from the inverted output.
    assign d = qn;

    // Priority: reset, then set/clear, then a clocked toggle, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q  <= 1'b1;
            qn <= 1'b0;
        end else if (!set_n || !clr_n) begin
            q  <= !set_n;
            qn <= !clr_n;
        end else if (tog_en) begin
            q  <= d;
            qn <= ~d;
        end
    end

    assert_one_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q || qn))
        else $error("no channel enabled");

endmodule

// File: rtl/vsel_adddet.sv
// Module: vsel_adddet
// Registered detector for the both-enabled condition. The both-low test is
// written as a NAND term. add_en follows it one clock later.
// Assumes: en_a and en_b are already registered.
module vsel_adddet (
    input  logic clk,
    input  logic rst_n,
    input  logic en_a,
    input  logic en_b,
    output logic add_en
);

    logic both_n;

    // NAND of the two enables: low only while both gates are on.
    assign both_n = ~(en_a & en_b);

    // Register the inverted NAND to produce the sum flag.
    always_ff @(posedge clk) begin
        if (!rst_n) add_en <= 1'b0;
        else        add_en <= ~both_n;
    end

    assert_add_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a && en_b) |=> add_en)
        else $error("sum flag missed");

    assert_add_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_a && en_b) |=> !add_en)
        else $error("sum flag spurious");

endmodule

// File: rtl/vchan_select.sv
// Module: vchan_select (top)
// Vertical channel mode selector. It decodes the switches, synchronises the
// sweep-end and chop timing inputs, steers the chosen event into the select
// flip-flop and flags sum operation.
// Assumes: the switches are quasi-static and need no synchroniser; the
// timing inputs are asynchronous.
module vchan_select
    import vsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xy_mode,
    input  logic [1:0] chan_sw,
    input  logic [1:0] mode_sw,
    input  logic       sweep_end,
    input  logic       chop_clk,
    output logic       ch1_en,
    output logic       ch2_en,
    output logic       add_en
);

    logic [NUM_EVT-1:0] evt_raw;
    logic [NUM_EVT-1:0] evt_pulse;
    logic               set_n;
    logic               clr_n;
    logic               tog_en;
    togsrc_e            tog_src;

    // Gather the timing inputs into one vector for the synchroniser array.
    always_comb begin
        evt_raw            = '0;
        evt_raw[EVT_SWEEP] = sweep_end;
        evt_raw[EVT_CHOP]  = chop_clk;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_EVT; gi++) begin : g_evt
            vsel_evt #(.STAGES(SYNC_STAGES)) u_evt (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_in    (evt_raw[gi]),
                .evt_pulse (evt_pulse[gi])
            );
        end
    endgenerate

    vsel_decode u_decode (
        .xy_mode (xy_mode),
        .chan    (chsw_e'(chan_sw)),
        .mode    (mode_e'(mode_sw)),
        .set_n   (set_n),
        .clr_n   (clr_n),
        .tog_src (tog_src)
    );

    // Pass only the event that belongs to the active time-shared mode.
    always_comb begin
        unique case (tog_src)
            TOG_SWEEP: tog_en = evt_pulse[EVT_SWEEP];
            TOG_CHOP:  tog_en = evt_pulse[EVT_CHOP];
            default:   tog_en = 1'b0;
        endcase
    end

    vsel_selff u_ff (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_n  (set_n),
        .clr_n  (clr_n),
        .tog_en (tog_en),
        .q      (ch1_en),
        .qn     (ch2_en)
    );

    vsel_adddet u_add (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_a   (ch1_en),
        .en_b   (ch2_en),
        .add_en (add_en)
    );

    assert_ch1_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xy_mode && chan_sw == 2'b00) |=> (ch1_en && !ch2_en))
        else $error("channel 1 position not honoured");

    assert_ch2_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xy_mode && chan_sw == 2'b10) |=> (!ch1_en && ch2_en))
        else $error("channel 2 position not honoured");

    assert_sum_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xy_mode && chan_sw == 2'b01 && mode_sw == 2'b00) |=> (ch1_en && ch2_en))
        else $error("sum position did not enable both");

    assert_xy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xy_mode |=> $stable({ch1_en, ch2_en}))
        else $error("enables moved in X-Y mode");

endmodule

// File: tb/vchan_select_tb.sv
// Bench for vchan_select: a table of static switch settings, walked by one
// loop, then directed tests for reset, toggle timing and corner cases.
module vchan_select_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xy_mode = 1'b0;
    logic [1:0] chan_sw = 2'b01;
    logic [1:0] mode_sw = 2'b01;
    logic       sweep_end = 1'b0;
    logic       chop_clk = 1'b0;
    logic       ch1_en, ch2_en, add_en;

    int n_chk = 0;
    int n_bad = 0;
    int n_none = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vchan_select u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .xy_mode   (xy_mode),
        .chan_sw   (chan_sw),
        .mode_sw   (mode_sw),
        .sweep_end (sweep_end),
        .chop_clk  (chop_clk),
        .ch1_en    (ch1_en),
        .ch2_en    (ch2_en),
        .add_en    (add_en)
    );

    // Entry: {xy, chan[1:0], mode[1:0], exp_ch1, exp_ch2}; the expected sum flag is exp_ch1 & exp_ch2.
    localparam int NVEC = 9;
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b0, 2'b00, 2'b00, 1'b1, 1'b0},  // R10: ch1 ignores sum mode
        {1'b0, 2'b10, 2'b10, 1'b0, 1'b1},  // R3
        {1'b0, 2'b01, 2'b00, 1'b1, 1'b1},  // R4, R5
        {1'b0, 2'b01, 2'b01, 1'b1, 1'b1},  // R8: alternate keeps both until an event
        {1'b0, 2'b10, 2'b01, 1'b0, 1'b1},  // R3, R10
        {1'b1, 2'b00, 2'b00, 1'b0, 1'b1},  // R9: X-Y holds
        {1'b0, 2'b11, 2'b00, 1'b0, 1'b1},  // R11: unused channel code
        {1'b0, 2'b00, 2'b10, 1'b1, 1'b0},  // R2
        {1'b0, 2'b01, 2'b11, 1'b1, 1'b0}   // R11: unused mode code
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {ch1,ch2,add} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic xy, input logic [1:0] ch, input logic [1:0] md);
        @(negedge clk);
        xy_mode = xy;
        chan_sw = ch;
        mode_sw = md;
    endtask

    task automatic pulse(input bit use_chop);
        @(negedge clk);
        if (use_chop) chop_clk = 1'b1; else sweep_end = 1'b1;
        repeat (4) @(negedge clk);
        if (use_chop) chop_clk = 1'b0; else sweep_end = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watch at every falling edge that at least one channel stays on.
    always @(negedge clk) begin
        if (mon_on && !ch1_en && !ch2_en) n_none++;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", {ch1_en, ch2_en, add_en}, 3'b100);
        mon_on = 1'b1;

        // Table walk over static switch settings.
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][6], VEC[i][5:4], VEC[i][3:2]);
            @(negedge clk);
            @(negedge clk);
            check($sformatf("R2/R3/R4/R8/R9/R10/R11 vector %0d", i),
                  {ch1_en, ch2_en, add_en},
                  {VEC[i][1], VEC[i][0], VEC[i][1] & VEC[i][0]});
        end

        // R5: exact latency of the sum flag.
        drive(1'b0, 2'b00, 2'b00);
        @(negedge clk);
        drive(1'b0, 2'b01, 2'b00);
        @(negedge clk);
        check("R5 enables up, flag not yet", {ch1_en, ch2_en, add_en}, 3'b110);
        @(negedge clk);
        check("R5 flag one clock later", {ch1_en, ch2_en, add_en}, 3'b111);
        drive(1'b0, 2'b00, 2'b00);
        @(negedge clk);
        check("R5 flag still high one clock", {ch1_en, ch2_en, add_en}, 3'b101);
        @(negedge clk);
        check("R5 flag drops", {ch1_en, ch2_en, add_en}, 3'b100);

        // R6: alternate mode, exact toggle latency.
        drive(1'b0, 2'b01, 2'b01);
        @(negedge clk);
        sweep_end = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 no swap after two edges", {ch1_en, ch2_en, add_en}, 3'b100);
        @(negedge clk);
        check("R6 swap on third edge", {ch1_en, ch2_en, add_en}, 3'b010);
        @(negedge clk);
        sweep_end = 1'b0;
        repeat (4) @(negedge clk);
        pulse(1'b0);
        check("R6 second sweep swaps back", {ch1_en, ch2_en, add_en}, 3'b100);
        pulse(1'b1);
        check("R6 chop ignored in alternate", {ch1_en, ch2_en, add_en}, 3'b100);

        // R7: chopped mode.
        drive(1'b0, 2'b01, 2'b10);
        pulse(1'b1);
        check("R7 chop swaps", {ch1_en, ch2_en, add_en}, 3'b010);
        pulse(1'b0);
        check("R7 sweep ignored in chopped", {ch1_en, ch2_en, add_en}, 3'b010);
        pulse(1'b1);
        check("R7 chop swaps back", {ch1_en, ch2_en, add_en}, 3'b100);

        // R8: leaving sum mode for chopped.
        drive(1'b0, 2'b01, 2'b00);
        repeat (2) @(negedge clk);
        drive(1'b0, 2'b01, 2'b10);
        repeat (3) @(negedge clk);
        check("R8 both held before event", {ch1_en, ch2_en, add_en}, 3'b111);
        pulse(1'b1);
        check("R8 first event selects ch1", {ch1_en, ch2_en, add_en}, 3'b100);

        // R9: X-Y mode ignores switches and events.
        drive(1'b1, 2'b10, 2'b10);
        pulse(1'b1);
        pulse(1'b0);
        check("R9 X-Y hold under events", {ch1_en, ch2_en, add_en}, 3'b100);
        drive(1'b1, 2'b01, 2'b00);
        repeat (3) @(negedge clk);
        check("R9 X-Y ignores sum request", {ch1_en, ch2_en, add_en}, 3'b100);

        // R10: events have no effect outside the both position.
        drive(1'b0, 2'b10, 2'b10);
        pulse(1'b1);
        check("R10 ch2 ignores chop", {ch1_en, ch2_en, add_en}, 3'b010);
        drive(1'b0, 2'b00, 2'b01);
        pulse(1'b0);
        check("R10 ch1 ignores sweep", {ch1_en, ch2_en, add_en}, 3'b100);

        // R11: unused channel code holds under events.
        drive(1'b0, 2'b11, 2'b10);
        pulse(1'b1);
        check("R11 unused channel code holds", {ch1_en, ch2_en, add_en}, 3'b100);

        // R12: monitor tally.
        n_chk++;
        if (n_none != 0) begin
            n_bad++;
            $display("FAIL R12: cycles with no channel actual=%0d expected=0", n_none);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule